// File: doc/BRIEF.md
# Transmit Flush and Remote Wakeup Controller

This block decides when bytes that sit in a transmit buffer, short of a full packet, are handed to the host. It watches the buffer fill level and a latency timer driven by a 1 ms tick. It also watches one active-low strobe pin that does two jobs. While the link is awake, a strobe asks for an immediate send. While the link is suspended, it asks for a resume.

The block has two outputs. The first is a level flag telling the packet engine to release everything pending on the next bulk IN request. The second is a one-cycle remote-wakeup request. The packet engine pulses a "served" input after each IN transfer and presents the updated buffer level. The flag clears once that level reads zero.

Top module: `txflush_ctrl`

## Requirements
- R1: After reset, `flush_o` and `wake_req_o` are 0.
- R2: With data pending (`tx_level` nonzero) and a timeout setting T of 1 to 255, `flush_o` rises in the cycle after the T-th `tick_1ms` pulse counted since the last `byte_push`. After T-1 such ticks it is still 0.
- R3: A timeout setting of 0 behaves exactly as a setting of 1.
- R4: A `byte_push` pulse restarts the latency count from zero. A tick in the same cycle as a push is not counted.
- R5: While `tx_level` is zero the latency count is held at zero, so ticks seen with an empty buffer never count.
- R6: While awake (`suspend_i`=0) with data pending, a high-to-low transition on `strobe_n` sets `flush_o`. The flag is visible after the third rising clock edge from the pin change, two synchroniser stages plus one register.
- R7: A strobe while awake with an empty buffer leaves `flush_o` at 0.
- R8: A strobe while suspended with `wake_en`=1 gives a single-cycle `wake_req_o` pulse at the same point a flush would appear, and it does not set `flush_o`.
- R9: A strobe while suspended with `wake_en`=0 changes neither output.
- R10: The strobe acts only on its falling edge. Holding `strobe_n` low produces no further flush or wakeup.
- R11: `flush_o` clears one cycle after an `in_served` pulse seen with `tx_level` at zero. An `in_served` pulse with data still pending leaves it set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_1ms | input | 1 | One-cycle pulse every millisecond |
| timeout_ms | input | 8 | Latency timeout setting in ms (0 acts as 1) |
| tx_level | input | 9 | Bytes currently held in the transmit buffer |
| byte_push | input | 1 | Pulse: a byte entered the transmit buffer |
| in_served | input | 1 | Pulse: an IN request was served, `tx_level` already updated |
| suspend_i | input | 1 | High while the link is suspended |
| wake_en | input | 1 | Remote wakeup permitted |
| strobe_n | input | 1 | Asynchronous active-low send-now / wakeup strobe |
| flush_o | output | 1 | Release all pending data on the next IN request |
| wake_req_o | output | 1 | One-cycle remote-wakeup request |

## Verification
A latency count that is off by one moves the rise of `flush_o` by a whole tick. Sweeping every timeout setting exposes this within one timeout period. A count that is not cleared on a push or on an empty buffer shows up as an early flush after the restart. A stuck edge detector or a wrong suspend decode shows within three cycles of a strobe, as a missing, repeated or misrouted pulse on `flush_o` or `wake_req_o`. A flag that fails to clear stays visible after the served pulse.

// File: rtl/txflush_pkg.sv
package txflush_pkg;
    parameter int TO_W  = 8;
    parameter int LVL_W = 9;

    typedef struct packed {
        logic flush;
        logic wake;
    } ctrl_st_t;
endpackage

// File: rtl/strobe_edge.sv
module strobe_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    output logic fall
);
    localparam int W = STAGES + 1;

    logic [W-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[W-2:0], pin_n};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '1;
        else        sh_q <= sh_d;
    end

    assign fall = sh_q[W-1] & ~sh_q[W-2];

    AST_EDGE_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        fall |=> !fall); // R10
endmodule

// File: rtl/latency_timer.sv
module latency_timer #(
    parameter int TO_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick,
    input  logic            push,
    input  logic            pending,
    input  logic [TO_W-1:0] timeout,
    output logic            expire
);
    logic [TO_W-1:0] cnt_d, cnt_q;
    logic [TO_W-1:0] limit;
    logic [TO_W:0]   cnt_inc;

    always_comb begin
        limit   = (timeout == '0) ? TO_W'(1) : timeout;
        cnt_inc = {1'b0, cnt_q} + 1'b1;
        expire  = pending && !push && tick && (cnt_inc >= {1'b0, limit});
        if (!pending || push)  cnt_d = '0;
        else if (expire)       cnt_d = '0;
        else if (tick)         cnt_d = cnt_inc[TO_W-1:0];
        else                   cnt_d = cnt_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    AST_EMPTY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !pending |=> (cnt_q == '0)); // R5
    AST_PUSH_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        push |=> (cnt_q == '0)); // R4
endmodule

// File: rtl/txflush_ctrl.sv
module txflush_ctrl
    import txflush_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_1ms,
    input  logic [TO_W-1:0]  timeout_ms,
    input  logic [LVL_W-1:0] tx_level,
    input  logic             byte_push,
    input  logic             in_served,
    input  logic             suspend_i,
    input  logic             wake_en,
    input  logic             strobe_n,
    output logic             flush_o,
    output logic             wake_req_o
);
    ctrl_st_t st_d, st_q;
    logic     pending;
    logic     expire;
    logic     fall;

    assign pending = (tx_level != '0);

    strobe_edge #(.STAGES(2)) u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .pin_n (strobe_n),
        .fall  (fall)
    );

    latency_timer #(.TO_W(TO_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick_1ms),
        .push    (byte_push),
        .pending (pending),
        .timeout (timeout_ms),
        .expire  (expire)
    );

    always_comb begin
        st_d      = st_q;
        st_d.wake = fall && suspend_i && wake_en;
        if (in_served && !pending) st_d.flush = 1'b0;
        if (expire || (fall && !suspend_i && pending)) st_d.flush = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flush_o    = st_q.flush;
    assign wake_req_o = st_q.wake;

    AST_WAKE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        wake_req_o |=> !wake_req_o); // R8
    AST_WAKE_SUSP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wake_req_o) |-> $past(suspend_i && wake_en)); // R9
    AST_FLUSH_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flush_o) |-> $past(tx_level != '0)); // R7
    AST_FLUSH_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flush_o) |-> $past(in_served && tx_level == '0)); // R11
endmodule

// File: tb/sim_txflush_ctrl.sv
`timescale 1ns/1ps
module sim_txflush_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_1ms = 1'b0;
    logic [7:0] timeout_ms = 8'd1;
    logic [8:0] tx_level = '0;
    logic       byte_push = 1'b0;
    logic       in_served = 1'b0;
    logic       suspend_i = 1'b0;
    logic       wake_en = 1'b0;
    logic       strobe_n = 1'b1;
    logic       flush_o, wake_req_o;

    int vectors = 0;
    int errors  = 0;
    int cycles  = 0;

    always #10 clk = ~clk;

    txflush_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .tick_1ms(tick_1ms), .timeout_ms(timeout_ms),
        .tx_level(tx_level), .byte_push(byte_push), .in_served(in_served),
        .suspend_i(suspend_i), .wake_en(wake_en), .strobe_n(strobe_n),
        .flush_o(flush_o), .wake_req_o(wake_req_o)
    );

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic check(input logic got, input logic exp, input string req);
        vectors++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %0b expected %0b at %0t", req, got, exp, $time);
        end
    endtask

    task automatic do_tick();
        tick_1ms = 1'b1; step(); tick_1ms = 1'b0; step();
    endtask

    task automatic do_push(input int lvl);
        tx_level = 9'(lvl); byte_push = 1'b1; step(); byte_push = 1'b0;
    endtask

    task automatic drain();
        tx_level = '0; in_served = 1'b1; step(); in_served = 1'b0; step();
    endtask

    task automatic release_strobe();
        strobe_n = 1'b1;
        for (int i = 0; i < 4; i++) step();
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog: got %0d cycles expected completion", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        int wakes;
        step(); step();
        check(flush_o, 1'b0, "R1 flush in reset");
        check(wake_req_o, 1'b0, "R1 wake in reset");
        rst_n = 1'b1;
        step();
        check(flush_o, 1'b0, "R1 flush after reset");
        check(wake_req_o, 1'b0, "R1 wake after reset");

        // R2 / R3: sweep every timeout setting
        for (int t = 0; t < 256; t++) begin
            int lim;
            lim = (t == 0) ? 1 : t;
            timeout_ms = 8'(t);
            do_push(5);
            for (int k = 0; k < lim - 1; k++) do_tick();
            check(flush_o, 1'b0, (t == 0) ? "R3 early" : "R2 early");
            tick_1ms = 1'b1; step(); tick_1ms = 1'b0;
            check(flush_o, 1'b1, (t == 0) ? "R3 expiry" : "R2 expiry");
            drain();
            check(flush_o, 1'b0, "R11 cleared when empty");
        end

        // R4: push restarts the count, tick with push ignored
        timeout_ms = 8'd5;
        do_push(3);
        for (int k = 0; k < 3; k++) do_tick();
        tick_1ms = 1'b1; do_push(4); tick_1ms = 1'b0;
        for (int k = 0; k < 4; k++) do_tick();
        check(flush_o, 1'b0, "R4 restart");
        do_tick();
        check(flush_o, 1'b1, "R4 expiry after restart");
        // R11: served with data left keeps flag
        tx_level = 9'd2; in_served = 1'b1; step(); in_served = 1'b0; step();
        check(flush_o, 1'b1, "R11 held with data");
        drain();

        // R5: empty buffer holds count at zero
        timeout_ms = 8'd4;
        do_push(2);
        for (int k = 0; k < 3; k++) do_tick();
        tx_level = '0; step();
        for (int k = 0; k < 6; k++) do_tick();
        tx_level = 9'd2;
        for (int k = 0; k < 3; k++) do_tick();
        check(flush_o, 1'b0, "R5 count cleared");
        do_tick();
        check(flush_o, 1'b1, "R5 expiry");
        drain();

        // R6: awake strobe with data
        timeout_ms = 8'd255;
        do_push(7);
        strobe_n = 1'b0; step(); step();
        check(flush_o, 1'b0, "R6 latency");
        step();
        check(flush_o, 1'b1, "R6 flush");
        check(wake_req_o, 1'b0, "R6 no wake");
        // R10: held low, clear, no re-trigger
        drain();
        tx_level = 9'd3;
        for (int k = 0; k < 10; k++) step();
        check(flush_o, 1'b0, "R10 held low no retrigger");
        release_strobe();
        drain();

        // R7: awake strobe with empty buffer
        strobe_n = 1'b0;
        for (int k = 0; k < 5; k++) step();
        check(flush_o, 1'b0, "R7 empty strobe");
        release_strobe();

        // R8: suspended, wakeup enabled
        suspend_i = 1'b1; wake_en = 1'b1; do_push(4);
        strobe_n = 1'b0; step(); step();
        check(wake_req_o, 1'b0, "R8 latency");
        step();
        check(wake_req_o, 1'b1, "R8 wake pulse");
        check(flush_o, 1'b0, "R8 no flush");
        step();
        check(wake_req_o, 1'b0, "R8 single cycle");
        wakes = 0;
        for (int k = 0; k < 10; k++) begin step(); if (wake_req_o) wakes++; end
        check(wakes == 0, 1'b1, "R10 no repeat wake");
        release_strobe();

        // R9: suspended, wakeup disabled
        wake_en = 1'b0;
        strobe_n = 1'b0;
        wakes = 0;
        for (int k = 0; k < 6; k++) begin step(); if (wake_req_o) wakes++; end
        check(wakes == 0, 1'b1, "R9 no wake");
        check(flush_o, 1'b0, "R9 no flush");
        release_strobe();
        suspend_i = 1'b0;
        drain();

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule